// File: doc/BRIEF.md
# Prescaled Watchdog Timer with Reset Flag

The block is a watchdog that counts oscillator cycles through a selectable power-of-two prescaler into a free-running counter. Software arms it by setting an enable bit in its control register and keeps it quiet by writing a one-shot clear bit before the counter wraps. If the counter overflows, the block drives a fixed-length reset pulse out to the system and sets a sticky status flag. Software reads this flag after any unexplained restart to learn that the watchdog caused it.

Two reset inputs reach the block. The power-on reset clears everything, including the status flag. The hardware reset clears the control state and the counters but leaves the flag untouched. The watchdog's own overflow clears the control register in the same way, so the watchdog is disarmed once its pulse has ended.

Top module: `wdog_top`

## Requirements
- R1: After power-on reset the control readback is 0x00, the reset output is low and the status flag is 0.
- R2: Control register layout: bit 0 is the enable, bit 1 is the clear strobe, and bits 6:4 are the prescale select. The clear bit and all other bits read back as 0, whatever value was written to them.
- R3: A write that sets the enable with select s, and that reaches the register at clock edge E, makes the reset output go high just after edge E + 2^CNT_W * 2^(s+3). The division ratios are therefore 8, 16, 32, ..., 1024.
- R4: Each overflow drives the reset output high for exactly PULSE_LEN (4) clock cycles.
- R5: An overflow sets the status flag. A hardware reset leaves the flag unchanged. A power-on reset clears it.
- R6: The flag is cleared only by a flag write with data 0. A flag write with data 1 has no effect.
- R7: An overflow clears the whole control register (enable and select). A hardware reset does the same, and no overflow follows until software enables the watchdog again.
- R8: A control write that has both the enable bit and the clear bit set zeroes the counter and the prescaler. The next overflow then comes one full period after that write.
- R9: A write that changes the select zeroes the prescaler but keeps the counter value.
- R10: Writing the enable as 0 stops counting and zeroes both counters. No overflow occurs while the watchdog is disabled.
- R11: Control writes are ignored while the reset pulse is high.
- R12: Rewriting the same enable and select without the clear bit does not change when the overflow occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| porN | input | 1 | Power-on reset, active low, asynchronous; clears all state |
| rstN | input | 1 | Hardware reset, active low, asynchronous; spares the status flag |
| ctrlWe | input | 1 | Control register write strobe |
| ctrlWdata | input | 8 | Control register write data |
| flagWe | input | 1 | Status flag write strobe |
| flagWdata | input | 1 | Status flag write data (only 0 has an effect) |
| ctrlRdata | output | 8 | Control register readback |
| wdResetFlag | output | 1 | Sticky flag: last reset came from a watchdog overflow |
| wdResetOut | output | 1 | Reset pulse driven on overflow |

## Verification
On every cycle the assertions check four things: the pulse length, the flag being set whenever a pulse starts, the control readback staying zero for the whole pulse, and the flag never falling except through a zero write. They also check that a disabled watchdog never starts a pulse and that the unused readback bits stay zero. The exact overflow period for each select, and the period restarts caused by a clear, a select change or a redundant rewrite, can only be shown by the bench. It measures the cycle of each overflow against the value computed from the write edge. The same applies to the way the flag survives a hardware reset but not a power-on reset.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic run;     // count enable
    logic preClr;  // zero the prescaler
    logic cntClr;  // zero the main counter
  } wdStrobe_t;

  localparam int CTRL_W  = 8;
  localparam int EN_BIT  = 0;
  localparam int CLR_BIT = 1;
  localparam int SEL_LSB = 4;
endpackage

// File: rtl/wdog_datapath.sv
module wdog_datapath
  import wdog_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int SEL_W      = 3,
  parameter int BASE_SHIFT = 3
) (
  input  logic             clk,
  input  logic             hwRstN,
  input  wdStrobe_t        strobe,
  input  logic [SEL_W-1:0] sel,
  output logic             overflow
);
  localparam int NSEL  = 1 << SEL_W;
  localparam int PRE_W = BASE_SHIFT + NSEL - 1;

  logic [PRE_W-1:0] preCnt;
  logic [CNT_W-1:0] cnt;
  logic [NSEL-1:0]  selHit;
  logic             tick;

  // One terminal-count comparator per select value
  for (genvar g = 0; g < NSEL; g++) begin : gHit
    localparam logic [PRE_W-1:0] TERM = PRE_W'((64'd1 << (BASE_SHIFT + g)) - 64'd1);
    assign selHit[g] = (preCnt == TERM);
  end

  assign tick     = strobe.run && selHit[sel];
  assign overflow = tick && (cnt == {CNT_W{1'b1}});

  always_ff @(posedge clk or negedge hwRstN) begin
    if (!hwRstN)           preCnt <= '0;
    else if (strobe.preClr) preCnt <= '0;
    else if (tick)          preCnt <= '0;
    else if (strobe.run)    preCnt <= preCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge hwRstN) begin
    if (!hwRstN)            cnt <= '0;
    else if (strobe.cntClr) cnt <= '0;
    else if (tick)          cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int SEL_W     = 3,
  parameter int PULSE_LEN = 4
) (
  input  logic              clk,
  input  logic              porN,
  input  logic              hwRstN,
  input  logic              ctrlWe,
  input  logic [CTRL_W-1:0] ctrlWdata,
  input  logic              flagWe,
  input  logic              flagWdata,
  input  logic              overflow,
  output wdStrobe_t         strobe,
  output logic [SEL_W-1:0]  sel,
  output logic [CTRL_W-1:0] ctrlRdata,
  output logic              wdResetFlag,
  output logic              wdResetOut
);
  localparam int PC_W = $clog2(PULSE_LEN + 1);

  logic             enableR;
  logic [SEL_W-1:0] selR;
  logic [PC_W-1:0]  pulseCnt;
  logic             flagR;
  logic             busy, wrOk, wrEn, wrClr;
  logic [SEL_W-1:0] wrSel;

  assign busy  = (pulseCnt != '0);
  assign wrOk  = ctrlWe && !busy;
  assign wrEn  = ctrlWdata[EN_BIT];
  assign wrClr = ctrlWdata[CLR_BIT];
  assign wrSel = ctrlWdata[SEL_LSB +: SEL_W];

  always_comb begin
    strobe.run    = enableR;
    strobe.cntClr = !enableR || overflow || (wrOk && (wrClr || !wrEn));
    strobe.preClr = strobe.cntClr || (wrOk && (wrSel != selR));
  end

  // Control register and reset pulse; overflow outranks a write
  always_ff @(posedge clk or negedge hwRstN) begin
    if (!hwRstN) begin
      enableR  <= 1'b0;
      selR     <= '0;
      pulseCnt <= '0;
    end else if (overflow) begin
      enableR  <= 1'b0;
      selR     <= '0;
      pulseCnt <= PC_W'(PULSE_LEN);
    end else begin
      if (busy) pulseCnt <= pulseCnt - 1'b1;
      if (wrOk) begin
        enableR <= wrEn;
        selR    <= wrSel;
      end
    end
  end

  // Sticky flag: only power-on reset or a zero write clears it
  always_ff @(posedge clk or negedge porN) begin
    if (!porN)                     flagR <= 1'b0;
    else if (overflow)             flagR <= 1'b1;
    else if (flagWe && !flagWdata) flagR <= 1'b0;
  end

  always_comb begin
    ctrlRdata                     = '0;
    ctrlRdata[EN_BIT]             = enableR;
    ctrlRdata[SEL_LSB +: SEL_W]   = selR;
  end

  assign sel         = selR;
  assign wdResetFlag = flagR;
  assign wdResetOut  = busy;
endmodule

// File: rtl/wdog_top.sv
module wdog_top
  import wdog_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int SEL_W      = 3,
  parameter int BASE_SHIFT = 3,
  parameter int PULSE_LEN  = 4
) (
  input  logic       clk,
  input  logic       porN,
  input  logic       rstN,
  input  logic       ctrlWe,
  input  logic [7:0] ctrlWdata,
  input  logic       flagWe,
  input  logic       flagWdata,
  output logic [7:0] ctrlRdata,
  output logic       wdResetFlag,
  output logic       wdResetOut
);
  logic             hwRstN;
  logic             overflow;
  wdStrobe_t        strobe;
  logic [SEL_W-1:0] sel;

  assign hwRstN = rstN & porN;

  wdog_ctrl #(.SEL_W(SEL_W), .PULSE_LEN(PULSE_LEN)) u_ctrl (
    .clk(clk), .porN(porN), .hwRstN(hwRstN),
    .ctrlWe(ctrlWe), .ctrlWdata(ctrlWdata),
    .flagWe(flagWe), .flagWdata(flagWdata),
    .overflow(overflow), .strobe(strobe), .sel(sel),
    .ctrlRdata(ctrlRdata), .wdResetFlag(wdResetFlag), .wdResetOut(wdResetOut)
  );

  wdog_datapath #(.CNT_W(CNT_W), .SEL_W(SEL_W), .BASE_SHIFT(BASE_SHIFT)) u_dp (
    .clk(clk), .hwRstN(hwRstN), .strobe(strobe), .sel(sel), .overflow(overflow)
  );
endmodule

// File: rtl/wdog_checker.sv
module wdog_checker #(
  parameter int PULSE_LEN = 4
) (
  input logic       clk,
  input logic       porN,
  input logic       rstN,
  input logic       flagWe,
  input logic       flagWdata,
  input logic [7:0] ctrlRdata,
  input logic       wdResetFlag,
  input logic       wdResetOut
);
  logic [15:0] hiCnt;

  always_ff @(posedge clk or negedge porN or negedge rstN) begin
    if (!porN || !rstN) hiCnt <= '0;
    else if (wdResetOut) hiCnt <= 16'(hiCnt + 16'd1);
    else hiCnt <= '0;
  end

  a_r4_pulse_len: assert property (@(posedge clk) disable iff (!porN || !rstN)
    $fell(wdResetOut) |-> (hiCnt == 16'(PULSE_LEN)));

  a_r4_pulse_max: assert property (@(posedge clk) disable iff (!porN || !rstN)
    hiCnt <= 16'(PULSE_LEN));

  a_r5_flag_on_pulse: assert property (@(posedge clk) disable iff (!porN || !rstN)
    $rose(wdResetOut) |-> wdResetFlag);

  a_r6_flag_clear_src: assert property (@(posedge clk) disable iff (!porN)
    $fell(wdResetFlag) |-> $past(flagWe && !flagWdata));

  // R7 and R11: register is zero and stays zero during the pulse
  a_r11_ctrl_quiet: assert property (@(posedge clk) disable iff (!porN || !rstN)
    wdResetOut |-> (ctrlRdata == 8'h00));

  a_r10_no_fire_disabled: assert property (@(posedge clk) disable iff (!porN || !rstN)
    (!ctrlRdata[0] && !wdResetOut) |=> !wdResetOut);

  a_r2_unused_zero: assert property (@(posedge clk) disable iff (!porN || !rstN)
    (ctrlRdata[7] == 1'b0) && (ctrlRdata[3:1] == 3'b000));
endmodule

bind wdog_top wdog_checker #(.PULSE_LEN(PULSE_LEN)) u_chk (.*);

// File: tb/wdog_top_bench.sv
module wdog_top_bench;
  localparam int CNT_W = 4;
  localparam int PULSE = 4;

  logic clk = 1'b0;
  logic porN = 1'b0, rstN = 1'b0;
  logic ctrlWe = 1'b0, flagWe = 1'b0, flagWdata = 1'b0;
  logic [7:0] ctrlWdata = 8'h00;
  logic [7:0] ctrlRdata;
  logic wdResetFlag, wdResetOut;

  int nChecks = 0, nFails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  wdog_top #(.CNT_W(CNT_W), .PULSE_LEN(PULSE)) u_wdog_top (
    .clk(clk), .porN(porN), .rstN(rstN), .ctrlWe(ctrlWe), .ctrlWdata(ctrlWdata),
    .flagWe(flagWe), .flagWdata(flagWdata), .ctrlRdata(ctrlRdata),
    .wdResetFlag(wdResetFlag), .wdResetOut(wdResetOut)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Called at a negedge; write lands on the following posedge
  task automatic wr(input logic [7:0] d);
    ctrlWe = 1'b1; ctrlWdata = d;
    @(negedge clk);
    ctrlWe = 1'b0; ctrlWdata = 8'h00;
  endtask

  task automatic flagWr(input logic d);
    flagWe = 1'b1; flagWdata = d;
    @(negedge clk);
    flagWe = 1'b0; flagWdata = 1'b0;
  endtask

  task automatic waitFire(input int limit, output int k);
    k = -1;
    for (int i = 1; i <= limit; i++) begin
      @(negedge clk);
      if (wdResetOut) begin k = i; break; end
    end
  endtask

  task automatic hiLen(output int n);
    n = 1;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (wdResetOut) n++; else break;
    end
  endtask

  function automatic int period(input int s);
    return (1 << CNT_W) * (1 << (s + 3));
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int k, n;
    repeat (3) @(negedge clk);
    porN = 1'b1; rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(ctrlRdata == 8'h00, "R1 ctrl", ctrlRdata, 0);
    chk(wdResetOut == 1'b0, "R1 out", wdResetOut, 0);
    chk(wdResetFlag == 1'b0, "R1 flag", wdResetFlag, 0);

    // R2 layout: enable bit0, select 6:4, others read 0
    wr(8'hFB);
    chk(ctrlRdata == 8'h71, "R2 readback", ctrlRdata, 8'h71);
    wr(8'h00);
    chk(ctrlRdata == 8'h00, "R2 disable", ctrlRdata, 0);

    // R3/R4/R5/R7/R6 sweep over every select
    for (int s = 0; s < 8; s++) begin
      wr(8'(8'h01 | (s << 4)));
      waitFire(period(s) + 20, k);
      chk(k == period(s), "R3 period", k, period(s));
      chk(wdResetFlag == 1'b1, "R5 flag set", wdResetFlag, 1);
      chk(ctrlRdata == 8'h00, "R7 ctrl cleared", ctrlRdata, 0);
      hiLen(n);
      chk(n == PULSE, "R4 pulse length", n, PULSE);
      flagWr(1'b1);
      chk(wdResetFlag == 1'b1, "R6 write one keeps", wdResetFlag, 1);
      flagWr(1'b0);
      chk(wdResetFlag == 1'b0, "R6 write zero clears", wdResetFlag, 0);
      flagWr(1'b1);
      chk(wdResetFlag == 1'b0, "R6 write one no set", wdResetFlag, 0);
    end

    // R8 clear restarts the period
    wr(8'h01);
    repeat (50) @(negedge clk);
    wr(8'h03);
    waitFire(200, k);
    chk(k == period(0), "R8 clear restart", k, period(0));
    hiLen(n);

    // R9 select change restarts the prescaler
    wr(8'h31);
    repeat (40) @(negedge clk);
    wr(8'h01);
    waitFire(400, k);
    chk(k == period(0), "R9 select change", k, period(0));
    hiLen(n);

    // R12 redundant rewrite keeps timing
    wr(8'h11);
    repeat (100) @(negedge clk);
    wr(8'h11);
    waitFire(400, k);
    chk(k == period(1) - 101, "R12 rewrite", k, period(1) - 101);
    hiLen(n);

    // R10 disable stops and zeroes counting
    wr(8'h01);
    repeat (50) @(negedge clk);
    wr(8'h00);
    waitFire(300, k);
    chk(k == -1, "R10 no fire disabled", k, -1);
    wr(8'h01);
    waitFire(200, k);
    chk(k == period(0), "R10 full period after enable", k, period(0));
    hiLen(n);

    // R11 writes ignored during the pulse
    wr(8'h01);
    waitFire(200, k);
    wr(8'h21);
    while (wdResetOut) @(negedge clk);
    chk(ctrlRdata == 8'h00, "R11 write ignored", ctrlRdata, 0);
    waitFire(period(2) + 50, k);
    chk(k == -1, "R11 no later fire", k, -1);

    // R5/R7 hardware reset keeps flag, clears control
    chk(wdResetFlag == 1'b1, "R5 flag before hw reset", wdResetFlag, 1);
    wr(8'h21);
    repeat (20) @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(ctrlRdata == 8'h00, "R7 hw reset clears ctrl", ctrlRdata, 0);
    chk(wdResetFlag == 1'b1, "R5 flag survives hw reset", wdResetFlag, 1);
    waitFire(period(2) + 50, k);
    chk(k == -1, "R7 disarmed after hw reset", k, -1);
    porN = 1'b0;
    @(negedge clk);
    porN = 1'b1;
    @(negedge clk);
    chk(wdResetFlag == 1'b0, "R5 power-on clears flag", wdResetFlag, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule